// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked master for a 32K x 8 asynchronous static RAM. On the memory side it drives an active-low chip select, an active-low output enable, an active-low write strobe and a 15-bit address. It shares an 8-bit bidirectional data bus with the memory. On the user side it takes single-byte read or write requests through a valid/ready handshake. Read data comes back with a one-cycle valid strobe.

Each phase of an access lasts a set number of clock cycles, chosen so that the memory's access, setup, pulse-width and hold times are met at the chosen clock. A read holds chip select and output enable low for a fixed window and samples the bus on the last clock of that window. A write raises output enable before it starts and then runs three phases with chip select held low: address setup, a write-strobe pulse, and a data hold. The controller drives the data bus only during the pulse and hold phases.

Between accesses chip select goes high. A sleep input parks the memory in deselected standby. When sleep is released, a full read-cycle time passes before a new request can be accepted.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n and mem_we_n are all 1, rsp_valid is 0, and req_ready is 1 while sleep is 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready stays 0 for the whole access that follows, and req_ready is 1 only while mem_ce_n is 1.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles with a steady address. It samples mem_dq at the end of the last of those cycles and raises rsp_valid for one cycle with that byte on rsp_rdata.
- R4: A write keeps mem_ce_n=0 throughout and runs three phases. First, SETUP_CYC cycles with mem_we_n=1. Then PULSE_CYC cycles with mem_we_n=0. Last, HOLD_CYC cycles with mem_we_n=1. The byte is driven on mem_dq only during the pulse and hold phases.
- R5: mem_oe_n is 1 whenever mem_we_n is 0, so the memory never drives the bus while the controller does.
- R6: mem_addr does not change while mem_ce_n stays 0, and mem_ce_n returns to 1 for at least one cycle between two accesses.
- R7: While sleep is 1 and no access is in progress, mem_ce_n stays 1 and req_ready is 0. A request presented then is not performed, so the addressed byte keeps its old value.
- R8: When sleep goes from 1 to 0, req_ready first returns to 1 in the (RD_CYC+1)-th cycle, and mem_ce_n stays 1 until then.
- R9: A read returns the byte most recently written to that address, or 0x00 for a byte never written. This holds when accesses are issued back to back and across the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep | input | 1 | Requests deselected low-power standby |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 8 | Read data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq | inout | 8 | Memory data bus |

## Verification
The assertions assume three things about the inputs:
- sleep and the request fields change only between clock edges.
- A request is held steady until it is taken.
- The memory drives the bus only while chip select and output enable are low and the write strobe is high.

The bench drives every input at the falling edge and keeps req_valid and the request fields fixed until the handshake completes. Its memory model drives mem_dq only under that exact condition, and until the access time has elapsed it drives inverted data, so early sampling shows up as a data mismatch. Sleep is raised only while the controller is idle, which keeps the standby checks within the case the assertions cover.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int RD_CYC    = 3,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq
);
  localparam int CW = $clog2(RD_CYC + SETUP_CYC + PULSE_CYC + HOLD_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SLEEP, S_WAKE, S_RD, S_WSET, S_WPUL, S_WHLD
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_q;
  logic          last, busy, drive;

  assign last      = (cnt == '0);
  assign busy      = (st == S_RD) || (st == S_WSET) || (st == S_WPUL) || (st == S_WHLD);
  assign drive     = (st == S_WPUL) || (st == S_WHLD);
  assign req_ready = (st == S_IDLE) && !sleep;
  assign mem_ce_n  = !busy;
  assign mem_oe_n  = (st != S_RD);
  assign mem_we_n  = (st != S_WPUL);
  assign mem_addr  = addr_q;
  assign mem_dq    = drive ? wdata_q : {DW{1'bz}};
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      if (!last) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE:
          if (sleep) st <= S_SLEEP;
          else if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            if (req_write) begin
              st  <= S_WSET;
              cnt <= CW'(SETUP_CYC - 1);
            end else begin
              st  <= S_RD;
              cnt <= CW'(RD_CYC - 1);
            end
          end
        S_SLEEP:
          if (!sleep) begin
            st  <= S_WAKE;
            cnt <= CW'(RD_CYC - 1);
          end
        S_WAKE:
          if (last) st <= S_IDLE;
        S_RD:
          if (last) begin
            rdata_q <= mem_dq;
            rsp_q   <= 1'b1;
            st      <= S_IDLE;
          end
        S_WSET:
          if (last) begin
            st  <= S_WPUL;
            cnt <= CW'(PULSE_CYC - 1);
          end
        S_WPUL:
          if (last) begin
            st  <= S_WHLD;
            cnt <= CW'(HOLD_CYC - 1);
          end
        S_WHLD:
          if (last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  no_oe_during_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  ready_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  // R7
  sleep_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && mem_ce_n) |=> mem_ce_n);

  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n && mem_we_n));
endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  localparam int RD = 3, SU = 1, PW = 2, HD = 1;

  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  wire  [7:0]  mem_dq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_ctrl #(.RD_CYC(RD), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq(mem_dq));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [7:0] mem [int];
  logic [7:0] m_val = '0;
  logic m_drv;
  assign m_drv  = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq = m_drv ? m_val : 8'hzz;

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  int rcnt = 0, wcnt = 0, cel = 0, chigh = 0;
  bit prev_rd = 0, prev_ce_lo = 0, woke = 0, prev_sleep = 0, was_wr = 0, pre_pulse = 1;
  logic [14:0] prev_addr = '0;

  always @(negedge clk) if (rst_n) begin
    bit rd_now;
    rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (!mem_oe_n && !mem_we_n) check(0, "R5 output enable low during write", 1, 0);
    if (!mem_ce_n && prev_ce_lo && mem_addr != prev_addr)
      check(0, "R6 address moved under chip select", int'(mem_addr), int'(prev_addr));
    if (rd_now) rcnt = prev_rd ? rcnt + 1 : 1;
    else if (prev_rd) begin
      check(rcnt == RD, "R3 read window length", rcnt, RD);
      rcnt = 0;
    end
    m_val = (rcnt >= RD) ? mem_rd(mem_addr) : ~mem_rd(mem_addr);
    if (!mem_ce_n && !mem_we_n) begin
      if (wcnt == 0) check(cel == SU, "R4 setup length", cel, SU);
      mem[int'(mem_addr)] = mem_dq;
      wcnt++;
      was_wr = 1;
    end else if (wcnt > 0) begin
      check(wcnt == PW, "R4 pulse width", wcnt, PW);
      wcnt = 0;
    end
    if (!mem_ce_n) begin
      if (!prev_ce_lo && woke) begin
        check(chigh >= RD + 1, "R8 recovery before first access", chigh, RD + 1);
        woke = 0;
      end
      cel++;
      chigh = 0;
    end else begin
      if (prev_ce_lo && was_wr) check(cel == SU + PW + HD, "R4 write cycle length", cel, SU + PW + HD);
      cel = 0;
      was_wr = 0;
      chigh++;
    end
    if (prev_sleep && !sleep) begin woke = 1; chigh = 0; end
    prev_sleep = sleep;
    prev_rd = rd_now;
    prev_ce_lo = !mem_ce_n;
    prev_addr = mem_addr;
  end

  // scoreboard
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) check(0, "R3 unexpected read strobe", 1, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      check(rsp_rdata == e, "R9 read data", int'(rsp_rdata), int'(e));
    end
  end

  task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R2 ready low during access", int'(req_ready), 0);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    shadow[int'(a)] = d;
    issue(1, a, d);
  endtask

  task automatic do_read(input logic [14:0] a);
    exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    issue(0, a, 8'h00);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    check(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset",
          {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(!rsp_valid, "R1 no response in reset", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);
    // R9 unwritten location
    do_read(15'h0123);
    do_write(15'h0000, 8'h5A);
    do_write(15'h7FFF, 8'hC3);
    do_write(15'h1234, 8'hFF);
    do_read(15'h0000);
    do_read(15'h7FFF);
    do_read(15'h1234);
    // back to back on one address
    do_write(15'h0042, 8'h11);
    do_read(15'h0042);
    do_write(15'h0042, 8'hEE);
    do_read(15'h0042);
    for (int i = 0; i < 8; i++) do_write(15'(i * 4097), 8'(i * 37 + 1));
    for (int i = 7; i >= 0; i--) do_read(15'(i * 4097));
    do_write(15'h0005, 8'h33);
    // R7 sleep
    while (!req_ready) @(negedge clk);
    sleep = 1;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 15'h0005; req_wdata = 8'h99;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(mem_ce_n && !req_ready, "R7 standby holds off requests",
            {30'd0, mem_ce_n, req_ready}, 2);
    end
    req_valid = 0;
    @(negedge clk);
    // R8 wake
    sleep = 0;
    begin
      int waited;
      waited = 0;
      do begin
        @(negedge clk);
        waited++;
        if (!req_ready) check(mem_ce_n, "R8 deselected while waking", int'(mem_ce_n), 1);
      end while (!req_ready && waited < 50);
      check(waited == RD + 1, "R8 wake latency", waited, RD + 1);
    end
    do_read(15'h0005);
    do_read(15'h7FFF);
    repeat (RD + 8) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
    finish_up();
  end
endmodule